// File: doc/BRIEF.md
# Buffer-Described SPI Transfer Engine

The engine runs one SPI transaction whose shape is described inside a shared 512-byte byte buffer instead of in registers. Software fills the buffer with a two-byte descriptor followed by the bytes to send, then writes a command word. The command word starts the job at once or arms it for an external trigger. It also names a timing profile and the peripheral select line to drive. The engine reads the descriptor and decodes the operation, the byte count and the lane width. It then clocks bytes out of the buffer and writes captured bytes back into it. A single-cycle done pulse marks the end.

The serial clock pace comes from an external bit-rate strobe. Each strobe moves the serial clock by one half period. The idle clock level is one global input. Each profile has one bit that chooses whether data is launched on the rising or the falling clock edge. Each select line has its own active level. In dual-lane mode both data lines carry data, two bits per clock. Line 1 carries the more significant bit of each pair.

Top module: `spi_cmd_engine`

## Requirements
- R1: The descriptor sits in buffer offset 0 (bits 15:8) and offset 1 (bits 7:0). Bits 15:13 give the operation: 1 = exchange, 2 = send only, 3 = receive only. 0 (sleep), 4 (interrupt marker) and 5..7 move no data. Bits 10:0 give the byte count.
- R2: A send operation shifts the bytes from buffer offset 2 upward, most significant bit first. In single-lane mode they go out on line 0. A receive-only operation sends 0x00 bytes.
- R3: A receive operation writes captured byte i to buffer offset i. In single-lane mode the bits come from line 1, most significant bit first. The descriptor bytes are overwritten by received data.
- R4: An exchange sends from offset 2+i and receives into offset i in the same byte time.
- R5: Descriptor bit 11 selects dual-lane mode for send-only and receive-only operations. Each clock then moves two bits, with line 1 as the higher bit. On an exchange, bit 11 is ignored and the transfer stays single-lane.
- R6: The count is clamped to 510 for operations that send and to 512 for receive-only. A count of 0, or a no-data operation, ends with done and never asserts a select line or toggles the clock.
- R7: Command bits 3:0 = 1 start the job at once. Code 2 arms it, and the job starts when the trigger input is high. Code 4 disarms it. The engine never leaves idle without a command write or a trigger.
- R8: A start command written while the engine is busy is ignored. The job in flight completes with its own byte count and gives exactly one done pulse.
- R9: Command code 3 during a job aborts it at the next edge. The select line is released and done is raised on the following cycle.
- R10: Command bits 14:12 choose the select line. Only that line is active during the job. Line k is active-high when polarity bit k is 1 and active-low otherwise. At rest, every line sits at its inactive level.
- R11: Command bits 11:8 pick a profile. When that profile's launch bit is 1, data changes on rising edges and is sampled on falling edges; when it is 0, the reverse. Outside a job the clock rests at the idle-level input.
- R12: Done is high for exactly one cycle. It is high in the cycle after the last byte completes, and by then the select line is already inactive.
- R13: Output enables are 01 for single-lane, 11 for dual-lane send, and 00 for dual-lane receive and at rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 16 | Command word: code 3:0, profile 11:8, select 14:12 |
| trig_i | input | 1 | External start trigger for an armed job |
| cs_pol_i | input | 8 | Per-line select polarity, 1 = active high |
| clk_idle_i | input | 1 | Idle level of the serial clock |
| launch_rise_i | input | 16 | Per-profile launch edge, 1 = rising |
| bit_en_i | input | 1 | Half-period strobe from the rate divider |
| buf_re_o | output | 1 | Buffer read enable, data returns next cycle |
| buf_we_o | output | 1 | Buffer write enable |
| buf_addr_o | output | 9 | Buffer byte address |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_rdata_i | input | 8 | Buffer read data |
| sclk_o | output | 1 | Serial clock |
| dat_o | output | 2 | Data line outputs |
| dat_oe_o | output | 2 | Data line output enables |
| dat_i | input | 2 | Data line inputs |
| cs_o | output | 8 | Peripheral select lines |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |

## Verification
The bench targets these corner cases:
- Every clock polarity and launch-edge pairing. A wrong phase makes the peripheral model sample shifted bits.
- Both lane widths, including a dual request on an exchange. An engine that obeys that request would send pairs that the single-lane model decodes wrongly.
- Counts above both clamp limits. Failing to clamp shows up as extra bytes, and clamping to the wrong limit as missing ones.
- A zero count and a sleep operation. A design that asserts the select line or toggles the clock here is caught by the select watcher.
- A start written during a job, a halt mid-byte, and arm/flush/trigger sequences. These expose extra done pulses, hung selects, and starts without a command.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [2:0] {
    OP_SLEEP = 3'd0, OP_XCHG = 3'd1, OP_SEND = 3'd2, OP_RECV = 3'd3, OP_MARK = 3'd4
  } op_e;

  localparam logic [3:0] CMD_NOP   = 4'd0;
  localparam logic [3:0] CMD_GO    = 4'd1;
  localparam logic [3:0] CMD_ARM   = 4'd2;
  localparam logic [3:0] CMD_HALT  = 4'd3;
  localparam logic [3:0] CMD_FLUSH = 4'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR0, S_HDR1, S_DEC, S_FETCH, S_FETCHW, S_SHIFT, S_STORE, S_DONE
  } state_e;
endpackage

// File: rtl/spi_eng_cmd.sv
module spi_eng_cmd import spi_eng_pkg::*; #(
  parameter int PROF_W = 4,
  parameter int SS_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [15:0]       cmd_i,
  input  logic              trig_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic              halt_o,
  output logic [PROF_W-1:0] prof_o,
  output logic [SS_W-1:0]   ss_o
);
  logic armed_q, go_now, arm_now, trig_go;
  logic [3:0] code;

  assign code    = cmd_i[3:0];
  assign go_now  = cmd_we_i && code == CMD_GO && !busy_i;
  assign arm_now = cmd_we_i && code == CMD_ARM && !busy_i;
  assign trig_go = armed_q && trig_i && !busy_i && !go_now;
  assign start_o = go_now || trig_go;
  assign halt_o  = cmd_we_i && code == CMD_HALT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      prof_o  <= '0;
      ss_o    <= '0;
    end else begin
      if (go_now || arm_now) begin
        prof_o <= cmd_i[8 +: PROF_W];
        ss_o   <= cmd_i[12 +: SS_W];
      end
      if (arm_now) armed_q <= 1'b1;
      else if (trig_go || go_now || halt_o || (cmd_we_i && code == CMD_FLUSH)) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       abort_i,
  input  logic [7:0] tx_i,
  input  logic       dual_i,
  input  logic       cpha_i,
  input  logic       tick_i,
  input  logic [1:0] dat_i,
  output logic [1:0] dat_o,
  output logic       ph_o,
  output logic [7:0] rx_o,
  output logic       end_o
);
  logic       act_q, ph_q;
  logic [2:0] slot_q, last_slot;
  logic [7:0] sh_q;
  logic [1:0] out_q;

  function automatic logic [1:0] lead(input logic [7:0] v, input logic d);
    return d ? v[7:6] : {1'b0, v[7]};
  endfunction
  function automatic logic [7:0] adv(input logic [7:0] v, input logic d);
    return d ? {v[5:0], 2'b00} : {v[6:0], 1'b0};
  endfunction
  function automatic logic [7:0] cap(input logic [7:0] v, input logic [1:0] s, input logic d);
    return d ? {v[5:0], s} : {v[6:0], s[1]};
  endfunction

  assign last_slot = dual_i ? 3'd3 : 3'd7;
  assign dat_o     = out_q;
  assign ph_o      = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; ph_q <= 1'b0; slot_q <= '0; sh_q <= '0;
      out_q <= '0; rx_o <= '0; end_o <= 1'b0;
    end else if (abort_i) begin
      act_q <= 1'b0; ph_q <= 1'b0; end_o <= 1'b0; out_q <= '0;
    end else begin
      end_o <= 1'b0;
      if (load_i) begin
        act_q <= 1'b1; ph_q <= 1'b0; slot_q <= '0; rx_o <= '0;
        if (!cpha_i) begin
          out_q <= lead(tx_i, dual_i);
          sh_q  <= adv(tx_i, dual_i);
        end else begin
          sh_q  <= tx_i;
        end
      end else if (act_q && tick_i) begin
        if (!ph_q) begin
          ph_q <= 1'b1;
          if (cpha_i) begin
            out_q <= lead(sh_q, dual_i);
            sh_q  <= adv(sh_q, dual_i);
          end else begin
            rx_o <= cap(rx_o, dat_i, dual_i);
          end
        end else begin
          ph_q <= 1'b0;
          if (cpha_i) rx_o <= cap(rx_o, dat_i, dual_i);
          if (slot_q == last_slot) begin
            act_q <= 1'b0;
            end_o <= 1'b1;
          end else begin
            slot_q <= slot_q + 3'd1;
            if (!cpha_i) begin
              out_q <= lead(sh_q, dual_i);
              sh_q  <= adv(sh_q, dual_i);
            end
          end
        end
      end
    end
  end

  AST_CLK_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !ph_q); // R11
endmodule

// File: rtl/spi_eng_cs.sv
module spi_eng_cs #(
  parameter int NUM_CS = 8,
  parameter int SS_W   = 3
) (
  input  logic              act_i,
  input  logic [SS_W-1:0]   ss_i,
  input  logic [NUM_CS-1:0] pol_i,
  output logic [NUM_CS-1:0] cs_o
);
  for (genvar k = 0; k < NUM_CS; k++) begin : g_line
    assign cs_o[k] = (act_i && ss_i == SS_W'(k)) ? pol_i[k] : ~pol_i[k];
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine import spi_eng_pkg::*; #(
  parameter int BUF_BYTES = 512,
  parameter int HDR_BYTES = 2,
  parameter int NUM_CS    = 8,
  parameter int NUM_PROF  = 16,
  localparam int AW       = $clog2(BUF_BYTES),
  localparam int PROF_W   = $clog2(NUM_PROF),
  localparam int SS_W     = $clog2(NUM_CS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_we_i,
  input  logic [15:0]         cmd_i,
  input  logic                trig_i,
  input  logic [NUM_CS-1:0]   cs_pol_i,
  input  logic                clk_idle_i,
  input  logic [NUM_PROF-1:0] launch_rise_i,
  input  logic                bit_en_i,
  output logic                buf_re_o,
  output logic                buf_we_o,
  output logic [AW-1:0]       buf_addr_o,
  output logic [7:0]          buf_wdata_o,
  input  logic [7:0]          buf_rdata_i,
  output logic                sclk_o,
  output logic [1:0]          dat_o,
  output logic [1:0]          dat_oe_o,
  input  logic [1:0]          dat_i,
  output logic [NUM_CS-1:0]   cs_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int LEN_W  = 11;
  localparam int TX_MAX = BUF_BYTES - HDR_BYTES;

  state_e            st_q;
  logic [7:0]        hdr_hi_q;
  logic              tx_q, rx_q, dual_q, cpha_q, cs_act_q;
  logic [AW:0]       len_q, cnt_q;
  logic [SS_W-1:0]   ss_q;
  logic              start, halt, byte_end, ph;
  logic [PROF_W-1:0] prof;
  logic [SS_W-1:0]   ss_cmd;
  logic [1:0]        sh_dat;
  logic [7:0]        rx_byte;
  op_e               hop;
  logic [LEN_W-1:0]  hlen, lim;
  logic              h_tx, h_rx;

  spi_eng_cmd #(.PROF_W(PROF_W), .SS_W(SS_W)) u_cmd (
    .clk_i, .rst_ni, .cmd_we_i, .cmd_i, .trig_i, .busy_i(busy_o),
    .start_o(start), .halt_o(halt), .prof_o(prof), .ss_o(ss_cmd)
  );

  spi_eng_shift u_shift (
    .clk_i, .rst_ni,
    .load_i(st_q == S_FETCHW), .abort_i(halt && busy_o),
    .tx_i(tx_q ? buf_rdata_i : 8'h00),
    .dual_i(dual_q), .cpha_i(cpha_q), .tick_i(bit_en_i), .dat_i,
    .dat_o(sh_dat), .ph_o(ph), .rx_o(rx_byte), .end_o(byte_end)
  );

  spi_eng_cs #(.NUM_CS(NUM_CS), .SS_W(SS_W)) u_cs (
    .act_i(cs_act_q), .ss_i(ss_q), .pol_i(cs_pol_i), .cs_o
  );

  assign hop  = op_e'(hdr_hi_q[7:5]);
  assign hlen = {hdr_hi_q[2:0], buf_rdata_i};
  assign h_tx = hop == OP_XCHG || hop == OP_SEND;
  assign h_rx = hop == OP_XCHG || hop == OP_RECV;
  assign lim  = h_tx ? LEN_W'(TX_MAX) : LEN_W'(BUF_BYTES);

  assign busy_o      = st_q != S_IDLE;
  assign done_o      = st_q == S_DONE;
  assign buf_re_o    = st_q == S_HDR0 || st_q == S_HDR1 || (st_q == S_FETCH && tx_q);
  assign buf_we_o    = st_q == S_STORE && rx_q;
  assign buf_wdata_o = rx_byte;
  assign sclk_o      = clk_idle_i ^ ph;
  assign dat_o       = cs_act_q ? sh_dat : 2'b00;

  always_comb begin
    unique case (st_q)
      S_HDR1:  buf_addr_o = AW'(1);
      S_FETCH: buf_addr_o = AW'(HDR_BYTES) + cnt_q[AW-1:0];
      S_STORE: buf_addr_o = cnt_q[AW-1:0];
      default: buf_addr_o = '0;
    endcase
    if (!cs_act_q)   dat_oe_o = 2'b00;
    else if (!dual_q) dat_oe_o = 2'b01;
    else             dat_oe_o = tx_q ? 2'b11 : 2'b00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; hdr_hi_q <= '0; tx_q <= 1'b0; rx_q <= 1'b0; dual_q <= 1'b0;
      cpha_q <= 1'b0; cs_act_q <= 1'b0; len_q <= '0; cnt_q <= '0; ss_q <= '0;
    end else if (halt && busy_o && st_q != S_DONE) begin
      st_q     <= S_DONE;
      cs_act_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE:   if (start) st_q <= S_HDR0;
        S_HDR0:   st_q <= S_HDR1;
        S_HDR1: begin
          hdr_hi_q <= buf_rdata_i;
          st_q     <= S_DEC;
        end
        S_DEC: begin
          tx_q   <= h_tx;
          rx_q   <= h_rx;
          dual_q <= hdr_hi_q[3] && (h_tx ^ h_rx);
          len_q  <= (AW+1)'(hlen > lim ? lim : hlen);
          cpha_q <= launch_rise_i[prof] ^ clk_idle_i;
          ss_q   <= ss_cmd;
          cnt_q  <= '0;
          if ((h_tx || h_rx) && hlen != '0) begin
            cs_act_q <= 1'b1;
            st_q     <= S_FETCH;
          end else begin
            st_q <= S_DONE;
          end
        end
        S_FETCH:  st_q <= S_FETCHW;
        S_FETCHW: st_q <= S_SHIFT;
        S_SHIFT:  if (byte_end) st_q <= S_STORE;
        S_STORE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q + 1'b1 == len_q) begin
            cs_act_q <= 1'b0;
            st_q     <= S_DONE;
          end else begin
            st_q <= S_FETCH;
          end
        end
        S_DONE:   st_q <= S_IDLE;
        default:  st_q <= S_IDLE;
      endcase
    end
  end

  AST_DONE_CS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_o == ~cs_pol_i); // R12
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_CLK_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o == ~cs_pol_i |-> sclk_o == clk_idle_i); // R11
  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_we_i || trig_i)); // R7
  AST_HALT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && cmd_we_i && cmd_i[3:0] == CMD_HALT |=> done_o); // R9
endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_we = 1'b0, trig = 1'b0, clk_idle = 1'b0, bit_en = 1'b0;
  logic [15:0] cmd = '0;
  logic [7:0]  cs_pol = 8'h05;
  logic [15:0] launch_rise = 16'h0020;
  logic        buf_re, buf_we, sclk, busy, done;
  logic [8:0]  buf_addr;
  logic [7:0]  buf_wdata, buf_rdata = '0;
  logic [1:0]  dat_out, dat_oe, dat_in = '0;
  logic [7:0]  cs;

  spi_cmd_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd), .trig_i(trig),
    .cs_pol_i(cs_pol), .clk_idle_i(clk_idle), .launch_rise_i(launch_rise), .bit_en_i(bit_en),
    .buf_re_o(buf_re), .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_wdata_o(buf_wdata),
    .buf_rdata_i(buf_rdata), .sclk_o(sclk), .dat_o(dat_out), .dat_oe_o(dat_oe), .dat_i(dat_in),
    .cs_o(cs), .busy_o(busy), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0, done_cnt = 0;
  logic [7:0] mem [512];
  logic [7:0] exp_q[$];
  logic [7:0] resp_q[$];
  logic [7:0] exp_rx [512];
  logic tb_dual = 0, tb_tx = 0, tb_chk = 0, tb_latch_rise = 1, cs_seen = 0;
  int   tb_ss = 0, sl_bits = 0;
  logic [7:0] sl_acc = '0, sl_resp = '0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // buffer model, one-cycle read latency
  initial forever begin
    @(posedge clk);
    if (buf_we) mem[buf_addr] <= buf_wdata;
    if (buf_re) buf_rdata <= mem[buf_addr];
  end

  initial forever begin
    @(negedge clk);
    bit_en <= ~bit_en;
  end

  initial forever begin
    @(posedge clk);
    if (done) done_cnt++;
    if (cs != ~cs_pol) cs_seen = 1;
  end

  task automatic slave_drive();
    logic [7:0] t;
    t = sl_resp << sl_bits;
    dat_in = tb_dual ? t[7:6] : {t[7], 1'b0};
  endtask

  // peripheral model and scoreboard monitor
  initial forever begin
    @(sclk);
    if (sclk == tb_latch_rise && cs[tb_ss] == cs_pol[tb_ss]) begin
      if (tb_dual) begin sl_acc = {sl_acc[5:0], dat_out}; sl_bits += 2; end
      else         begin sl_acc = {sl_acc[6:0], dat_out[0]}; sl_bits += 1; end
      if (sl_bits == 8) begin
        sl_bits = 0;
        if (tb_chk) begin
          if (exp_q.size() == 0) check(0, "R2 unexpected byte", sl_acc, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(sl_acc == e, "R2/R4/R5 sent byte", sl_acc, e);
          end
          check(cs == (~cs_pol ^ (8'd1 << tb_ss)), "R10 select pattern", cs, ~cs_pol ^ (8'd1 << tb_ss));
          check(dat_oe == (tb_dual ? (tb_tx ? 2'b11 : 2'b00) : 2'b01), "R13 enables", dat_oe,
                tb_dual ? (tb_tx ? 3 : 0) : 1);
        end
        sl_resp = resp_q.size() ? resp_q.pop_front() : 8'hFF;
      end
      #1 slave_drive();
    end
  end

  task automatic issue(input logic [3:0] code, input int ss, input int prof);
    @(negedge clk);
    cmd = {1'b0, 3'(ss), 4'(prof), 4'h0, code};
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_done(input int limit, input string req);
    int start = done_cnt, n = 0;
    while (done_cnt == start && n < limit) begin @(negedge clk); n++; end
    check(done_cnt != start, req, 0, 1);
  endtask

  // driver: builds the descriptor, pushes expected bytes, starts the job
  task automatic xfer(input logic [2:0] op, input bit dual, input int len, input int ss,
                      input int prof, input logic [3:0] code, input bit chk, input bit dowait);
    bit tx = (op == 1 || op == 2), rx = (op == 1 || op == 3);
    int n = (!(tx || rx)) ? 0 : (len > (tx ? 510 : 512) ? (tx ? 510 : 512) : len);
    exp_q.delete(); resp_q.delete();
    mem[0] = {op, 1'b0, dual, 3'(len >> 8)};
    mem[1] = 8'(len);
    for (int i = 0; i < 510; i++) mem[2+i] = 8'(i * 11 + 3);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(tx ? mem[2+i] : 8'h00);
      exp_rx[i] = 8'(i * 37 + 5);
      resp_q.push_back(exp_rx[i]);
    end
    tb_dual = dual && (op == 2 || op == 3);
    tb_tx = tx; tb_ss = ss; tb_chk = chk;
    tb_latch_rise = !launch_rise[prof];
    sl_bits = 0; sl_acc = '0;
    sl_resp = resp_q.size() ? resp_q.pop_front() : 8'hFF;
    slave_drive();
    issue(code, ss, prof);
    if (dowait) wait_done(20000, "R12 done seen");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    check(cs == ~cs_pol, "R10 reset selects", cs, ~cs_pol);
    check(!done && !busy, "R12 reset idle", {done, busy}, 0);
    check(sclk == clk_idle && dat_oe == 0, "R11 reset clock", {sclk, dat_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 send-only, mode 0, select 2 active high
    xfer(3'd2, 0, 3, 2, 0, 4'd1, 1, 1);
    check(exp_q.size() == 0, "R2 all bytes sent", exp_q.size(), 0);
    check(cs == ~cs_pol, "R12 select released", cs, ~cs_pol);

    // R3 receive-only, select 1 active low
    mem[2] = 8'h77;
    xfer(3'd3, 0, 2, 1, 0, 4'd1, 1, 1);
    check(mem[0] == exp_rx[0] && mem[1] == exp_rx[1], "R3 captured bytes", {mem[0], mem[1]},
          {exp_rx[0], exp_rx[1]});
    check(mem[2] == 8'h03, "R3 beyond count untouched", mem[2], 8'h03);

    // R4 exchange, clock idle high, profile 0 (launch falling) and profile 5 (launch rising)
    clk_idle = 1'b1;
    xfer(3'd1, 0, 4, 0, 0, 4'd1, 1, 1);
    check(exp_q.size() == 0 && mem[3] == exp_rx[3], "R4 exchange mode3", mem[3], exp_rx[3]);
    xfer(3'd1, 0, 3, 3, 5, 4'd1, 1, 1);
    check(exp_q.size() == 0 && mem[2] == exp_rx[2], "R11 exchange launch rising", mem[2], exp_rx[2]);
    clk_idle = 1'b0;
    xfer(3'd1, 0, 2, 4, 5, 4'd1, 1, 1);
    check(exp_q.size() == 0 && mem[1] == exp_rx[1], "R11 idle low launch rising", mem[1], exp_rx[1]);

    // R5 dual send, dual receive, dual ignored on exchange
    xfer(3'd2, 1, 2, 6, 0, 4'd1, 1, 1);
    check(exp_q.size() == 0, "R5 dual send", exp_q.size(), 0);
    xfer(3'd3, 1, 2, 7, 0, 4'd1, 1, 1);
    check(mem[0] == exp_rx[0] && mem[1] == exp_rx[1], "R5 dual receive", mem[1], exp_rx[1]);
    xfer(3'd1, 1, 2, 2, 0, 4'd1, 1, 1);
    check(exp_q.size() == 0 && mem[1] == exp_rx[1], "R5 exchange stays single", mem[1], exp_rx[1]);

    // R6 zero count and sleep
    cs_seen = 0;
    xfer(3'd2, 0, 0, 2, 0, 4'd1, 1, 1);
    xfer(3'd0, 0, 5, 2, 0, 4'd1, 1, 1);
    xfer(3'd4, 0, 5, 2, 0, 4'd1, 1, 1);
    check(!cs_seen, "R6 no select on empty job", cs_seen, 0);

    // R6 clamps
    xfer(3'd2, 0, 600, 1, 0, 4'd1, 1, 1);
    check(exp_q.size() == 0, "R6 send clamp 510", exp_q.size(), 0);
    xfer(3'd3, 0, 600, 1, 0, 4'd1, 1, 1);
    check(mem[511] == exp_rx[511] && mem[0] == exp_rx[0], "R6 receive clamp 512", mem[511], exp_rx[511]);

    // R8 start while busy
    d0 = done_cnt;
    xfer(3'd2, 0, 4, 2, 0, 4'd1, 1, 0);
    repeat (20) @(negedge clk);
    issue(4'd1, 2, 0);
    wait_done(5000, "R8 job completes");
    repeat (60) @(negedge clk);
    check(done_cnt == d0 + 1 && !busy, "R8 one done only", done_cnt - d0, 1);
    check(exp_q.size() == 0, "R8 byte count kept", exp_q.size(), 0);

    // R9 halt mid-transfer
    xfer(3'd2, 0, 8, 2, 0, 4'd1, 0, 0);
    repeat (30) @(negedge clk);
    check(busy && cs == (~cs_pol ^ 8'h04), "R10 select during job", cs, ~cs_pol ^ 8'h04);
    d0 = done_cnt;
    issue(4'd3, 2, 0);
    repeat (2) @(negedge clk);
    check(done_cnt == d0 + 1, "R9 done after halt", done_cnt - d0, 1);
    check(cs == ~cs_pol && !busy && sclk == clk_idle, "R9 released", cs, ~cs_pol);

    // R7 arm then trigger; arm, flush, trigger does nothing
    xfer(3'd2, 0, 2, 2, 0, 4'd2, 1, 0);
    repeat (30) @(negedge clk);
    check(!busy, "R7 armed waits", busy, 0);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    wait_done(5000, "R7 trigger starts");
    check(exp_q.size() == 0, "R7 triggered bytes", exp_q.size(), 0);
    d0 = done_cnt;
    xfer(3'd2, 0, 2, 2, 0, 4'd2, 0, 0);
    issue(4'd4, 2, 0);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    repeat (30) @(negedge clk);
    check(!busy && done_cnt == d0, "R7 flush disarms", done_cnt - d0, 0);

    // R1 descriptor overwritten and decoded; command without code 1/2 has no effect
    issue(4'd0, 2, 0);
    repeat (10) @(negedge clk);
    check(!busy && done_cnt == d0, "R1 no-op command", busy, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule